// File: doc/BRIEF.md
# Edge Change-Detect Interrupt Controller

The block watches a bank of digital input lines grouped into byte-wide ports (four ports of eight lines by default). It resynchronises the lines to the core clock and compares each synchronised sample with the one before it to find rising and falling transitions. Each port has two enable masks, one for rising and one for falling transitions, with one bit per line. A transition counts only when its line's mask bit is set and its edge type is enabled in the control register. Such a transition latches a single edge flag. If a counted transition arrives while the edge flag is still set, an overflow flag is latched as well.

Software reaches the block over a simple byte-wide register bus. The bus provides an identification byte, a status byte, a write-one-to-clear strobe register, a control byte, and the per-port mask registers. The interrupt line is driven from the latched flags, gated by their individual enables and by a master enable. To arm the block, software clears both flags and then writes 0x1D to the control register. To disarm it, software writes zero to the control register.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, all masks, both flags and all control bits read as zero, `irq` is low, and address 0x00 reads the identification value (default 0x5C).
- R2: For port p, the rising mask sits at 0x42 + 0x10·p and the falling mask at 0x43 + 0x10·p, with bit i covering line 8·p + i. The control register sits at 0x03. All of these registers read back what was written to them.
- R3: A low-to-high transition on a line sets status bit 0 (edge flag) when that line's rising mask bit is 1 and control bit 3 (rising type enable) is 1.
- R4: A high-to-low transition on a line sets status bit 0 when that line's falling mask bit is 1 and control bit 4 (falling type enable) is 1.
- R5: A transition on a line whose mask bit for that direction is 0, or whose type enable is 0, leaves the status byte unchanged.
- R6: A counted transition that arrives while the edge flag is already set also sets status bit 1 (overflow). The edge flag stays set.
- R7: Writing 0x01 with bit 3 set clears the edge flag. Writing 0x01 with bit 2 set clears the overflow flag. One write with both bits clears both flags. Writes to 0x01 with neither bit set change nothing. When a new counted transition arrives in the same cycle as a clear, the transition wins.
- R8: `irq` equals control bit 2 (master) AND ((edge flag AND control bit 0) OR (overflow flag AND control bit 1)). Status bit 2 reports `irq`.
- R9: Writing 0x00 to the control register drops `irq` while the flags are kept. Clearing the flags and then writing 0x1D arms the block, so that a counted rising edge raises `irq`.
- R10: The identification register at 0x00 is read-only. Writes to it have no effect.
- R11: Each input line passes through two synchroniser flops before comparison. A line changed before clock edge k sets the edge flag at edge k+2 and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lines_in | input | 32 | Asynchronous digital input lines, port p at bits 8p+7..8p |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request, active high |

## Verification
Transitions are driven in both directions on lines in different ports. This separates a rising mask from a falling mask and one port's registers from another's. Transitions on unmasked lines, and transitions with the type enable off, show that qualification needs both the mask bit and the type enable. Repeated toggles of a single enabled line before any clear separate the overflow path from the plain edge latch. Control values that mix the master, edge and overflow enables in different ways show which flag drives `irq`.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

   localparam int BUS_W = 8;

   // fixed register addresses
   localparam int ADDR_ID     = 'h00;
   localparam int ADDR_CLEAR  = 'h01;
   localparam int ADDR_STATUS = 'h02;
   localparam int ADDR_CTRL   = 'h03;

   // offsets inside a port window
   localparam int OFS_RISE = 2;
   localparam int OFS_FALL = 3;

   // clear strobe bits
   localparam int CLR_EDGE_BIT = 3;
   localparam int CLR_OVF_BIT  = 2;

   typedef struct packed {
      logic fall_en;    // bit 4
      logic rise_en;    // bit 3
      logic master_en;  // bit 2
      logic ovf_ie;     // bit 1
      logic edge_ie;    // bit 0
   } ctl_t;

   localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/edge_sync_det.sv
module edge_sync_det #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw_in,
   output logic [WIDTH-1:0] went_high,
   output logic [WIDTH-1:0] went_low
);

   if (STAGES < 2) begin : g_bad_stages
      $error("edge_sync_det: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg_q [STAGES];
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
         prev_q <= '0;
      end else begin
         stg_q[0] <= raw_in;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
         prev_q <= stg_q[STAGES-1];
      end
   end

   assign went_high = stg_q[STAGES-1] & ~prev_q;
   assign went_low  = ~stg_q[STAGES-1] & prev_q;

endmodule

// File: rtl/edge_port_qual.sv
module edge_port_qual #(
   parameter int PORT_W = 8
) (
   input  logic [PORT_W-1:0] went_high,
   input  logic [PORT_W-1:0] went_low,
   input  logic [PORT_W-1:0] rise_mask,
   input  logic [PORT_W-1:0] fall_mask,
   input  logic              rise_en,
   input  logic              fall_en,
   output logic              port_hit
);

   logic rise_any;
   logic fall_any;

   assign rise_any = |(went_high & rise_mask);
   assign fall_any = |(went_low & fall_mask);
   assign port_hit = (rise_any & rise_en) | (fall_any & fall_en);

endmodule

// File: rtl/edge_irq_regs.sv
module edge_irq_regs
   import edge_irq_pkg::*;
#(
   parameter int              NUM_PORTS   = 4,
   parameter int              PORT_W      = 8,
   parameter int              ADDR_W      = 8,
   parameter int              PORT_BASE   = 'h40,
   parameter int              PORT_STRIDE = 'h10,
   parameter logic [BUS_W-1:0] ID_VALUE   = 8'h5C
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [ADDR_W-1:0]                bus_addr,
   input  logic                             bus_wr,
   input  logic [BUS_W-1:0]                 bus_wdata,
   output logic [BUS_W-1:0]                 bus_rdata,
   input  logic                             any_hit,
   output logic [NUM_PORTS-1:0][PORT_W-1:0] rise_mask,
   output logic [NUM_PORTS-1:0][PORT_W-1:0] fall_mask,
   output ctl_t                             ctl,
   output logic                             edge_flag,
   output logic                             ovf_flag,
   output logic                             irq
);

   localparam logic [ADDR_W-1:0] A_ID     = ADDR_W'(ADDR_ID);
   localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(ADDR_CLEAR);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(ADDR_STATUS);
   localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(ADDR_CTRL);

   logic [BUS_W-1:0] port_rd [NUM_PORTS];

   // per-port mask registers
   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      localparam logic [ADDR_W-1:0] A_RISE = ADDR_W'(PORT_BASE + p*PORT_STRIDE + OFS_RISE);
      localparam logic [ADDR_W-1:0] A_FALL = ADDR_W'(PORT_BASE + p*PORT_STRIDE + OFS_FALL);

      logic [PORT_W-1:0] rise_q;
      logic [PORT_W-1:0] fall_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rise_q <= '0;
            fall_q <= '0;
         end else if (bus_wr) begin
            if (bus_addr == A_RISE) rise_q <= bus_wdata[PORT_W-1:0];
            if (bus_addr == A_FALL) fall_q <= bus_wdata[PORT_W-1:0];
         end
      end

      assign rise_mask[p] = rise_q;
      assign fall_mask[p] = fall_q;

      always_comb begin
         port_rd[p] = '0;
         if (bus_addr == A_RISE) port_rd[p] = BUS_W'(rise_q);
         if (bus_addr == A_FALL) port_rd[p] = BUS_W'(fall_q);
      end
   end

   // control register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ctl <= '0;
      else if (bus_wr && bus_addr == A_CTRL) ctl <= ctl_t'(bus_wdata[CTL_W-1:0]);
   end

   // flags: a new event wins over a clear in the same cycle
   logic clr_wr;
   logic clr_edge;
   logic clr_ovf;

   assign clr_wr   = bus_wr && (bus_addr == A_CLEAR);
   assign clr_edge = clr_wr & bus_wdata[CLR_EDGE_BIT];
   assign clr_ovf  = clr_wr & bus_wdata[CLR_OVF_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_flag <= 1'b0;
         ovf_flag  <= 1'b0;
      end else begin
         edge_flag <= any_hit | (edge_flag & ~clr_edge);
         ovf_flag  <= (any_hit & edge_flag) | (ovf_flag & ~clr_ovf);
      end
   end

   assign irq = ctl.master_en & ((edge_flag & ctl.edge_ie) | (ovf_flag & ctl.ovf_ie));

   // read mux
   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_ID:     bus_rdata = ID_VALUE;
         A_STATUS: bus_rdata = {{(BUS_W-3){1'b0}}, irq, ovf_flag, edge_flag};
         A_CTRL:   bus_rdata = BUS_W'(ctl);
         default: begin
            for (int p = 0; p < NUM_PORTS; p++) bus_rdata = bus_rdata | port_rd[p];
         end
      endcase
   end

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
   import edge_irq_pkg::*;
#(
   parameter int               NUM_PORTS   = 4,
   parameter int               PORT_W      = 8,
   parameter int               SYNC_STAGES = 2,
   parameter int               ADDR_W      = 8,
   parameter int               PORT_BASE   = 'h40,
   parameter int               PORT_STRIDE = 'h10,
   parameter logic [BUS_W-1:0] ID_VALUE    = 8'h5C,
   localparam int              LINES       = NUM_PORTS * PORT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINES-1:0]  lines_in,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              irq
);

   if (NUM_PORTS < 1) begin : g_bad_ports
      $error("edge_irq_ctrl: NUM_PORTS must be at least 1");
   end
   if (PORT_W < 1 || PORT_W > BUS_W) begin : g_bad_width
      $error("edge_irq_ctrl: PORT_W must be 1..BUS_W");
   end
   if (PORT_STRIDE < 4 || PORT_BASE < 4) begin : g_bad_stride
      $error("edge_irq_ctrl: port windows overlap fixed registers");
   end
   if (PORT_BASE + NUM_PORTS*PORT_STRIDE > (1 << ADDR_W)) begin : g_bad_span
      $error("edge_irq_ctrl: port windows exceed address space");
   end

   logic [LINES-1:0]                 went_high;
   logic [LINES-1:0]                 went_low;
   logic [NUM_PORTS-1:0][PORT_W-1:0] rise_mask;
   logic [NUM_PORTS-1:0][PORT_W-1:0] fall_mask;
   logic [NUM_PORTS-1:0]             port_hit;
   logic                             any_hit;
   ctl_t                             ctl_q;
   logic                             edge_flag;
   logic                             ovf_flag;

   edge_sync_det #(
      .WIDTH (LINES),
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_in   (lines_in),
      .went_high(went_high),
      .went_low (went_low)
   );

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_qual
      edge_port_qual #(
         .PORT_W(PORT_W)
      ) u_qual (
         .went_high(went_high[p*PORT_W +: PORT_W]),
         .went_low (went_low[p*PORT_W +: PORT_W]),
         .rise_mask(rise_mask[p]),
         .fall_mask(fall_mask[p]),
         .rise_en  (ctl_q.rise_en),
         .fall_en  (ctl_q.fall_en),
         .port_hit (port_hit[p])
      );
   end

   assign any_hit = |port_hit;

   edge_irq_regs #(
      .NUM_PORTS  (NUM_PORTS),
      .PORT_W     (PORT_W),
      .ADDR_W     (ADDR_W),
      .PORT_BASE  (PORT_BASE),
      .PORT_STRIDE(PORT_STRIDE),
      .ID_VALUE   (ID_VALUE)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_wr   (bus_wr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .any_hit  (any_hit),
      .rise_mask(rise_mask),
      .fall_mask(fall_mask),
      .ctl      (ctl_q),
      .edge_flag(edge_flag),
      .ovf_flag (ovf_flag),
      .irq      (irq)
   );

endmodule

// File: rtl/edge_irq_chk.sv
module edge_irq_chk
   import edge_irq_pkg::*;
#(
   parameter int               ADDR_W   = 8,
   parameter logic [BUS_W-1:0] ID_VALUE = 8'h5C
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [BUS_W-1:0]  bus_wdata,
   input logic [BUS_W-1:0]  bus_rdata,
   input logic              irq,
   input logic              edge_flag,
   input logic              ovf_flag,
   input logic              any_hit,
   input logic [CTL_W-1:0]  ctl_bits
);

   // R3/R4: the edge flag only rises after a qualified event
   p_edge_needs_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(edge_flag) |-> $past(any_hit));

   // R6: overflow only appears on top of an already latched edge
   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> (edge_flag && $past(edge_flag)));

   // R7: an edge clear with no competing event empties the flag
   p_clear_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(ADDR_CLEAR) && bus_wdata[CLR_EDGE_BIT] && !any_hit)
      |=> !edge_flag);

   // R8: master enable gates the request
   p_master_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_bits[2] |-> !irq);

   // R8: a request always has a latched cause
   p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (edge_flag || ovf_flag));

   // R10: identification byte is constant
   p_id_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(ADDR_ID)) |-> (bus_rdata == ID_VALUE));

endmodule

bind edge_irq_ctrl edge_irq_chk #(
   .ADDR_W  (ADDR_W),
   .ID_VALUE(ID_VALUE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_wr   (bus_wr),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .irq      (irq),
   .edge_flag(edge_flag),
   .ovf_flag (ovf_flag),
   .any_hit  (any_hit),
   .ctl_bits (ctl_q)
);

// File: tb/sim_edge_irq_ctrl.sv
module sim_edge_irq_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] lines = '0;
   logic [7:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   edge_irq_ctrl u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .lines_in (lines),
      .bus_addr (addr),
      .bus_wr   (wr_en),
      .bus_wdata(wdata),
      .bus_rdata(rdata),
      .irq      (irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic set_line(input int idx, input logic v);
      @(negedge clk);
      lines[idx] = v;
      repeat (4) @(negedge clk);
   endtask

   task automatic expect_status(input string req, input logic [7:0] exp);
      logic [7:0] v;
      rd(8'h02, v);
      check(req, {24'h0, v}, {24'h0, exp});
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd(8'h00, v); check("R1 id", {24'h0, v}, 32'h5C);
      rd(8'h03, v); check("R1 ctrl", {24'h0, v}, 32'h0);
      for (int p = 0; p < 4; p++) begin
         rd(8'(8'h42 + 16*p), v); check("R1 rise mask", {24'h0, v}, 32'h0);
         rd(8'(8'h43 + 16*p), v); check("R1 fall mask", {24'h0, v}, 32'h0);
      end
      expect_status("R1 status", 8'h00);
      check("R1 irq", {31'h0, irq}, 32'h0);
      wr(8'h00, 8'hFF);
      rd(8'h00, v); check("R10 id write ignored", {24'h0, v}, 32'h5C);
   endtask

   task automatic t_regmap();
      logic [7:0] v;
      for (int p = 0; p < 4; p++) begin
         wr(8'(8'h42 + 16*p), 8'(8'h11 * (p + 1)));
         wr(8'(8'h43 + 16*p), 8'(8'h80 | p));
      end
      for (int p = 0; p < 4; p++) begin
         rd(8'(8'h42 + 16*p), v); check("R2 rise readback", {24'h0, v}, 32'(8'(8'h11 * (p + 1))));
         rd(8'(8'h43 + 16*p), v); check("R2 fall readback", {24'h0, v}, 32'(8'h80 | p));
      end
      wr(8'h03, 8'h15);
      rd(8'h03, v); check("R2 ctrl readback", {24'h0, v}, 32'h15);
      wr(8'h03, 8'h00);
      for (int p = 0; p < 4; p++) begin
         wr(8'(8'h42 + 16*p), 8'h00);
         wr(8'(8'h43 + 16*p), 8'h00);
      end
      expect_status("R2 no flag from config", 8'h00);
   endtask

   task automatic t_rise_latency();
      wr(8'h52, 8'h08);          // port1 bit3 = line 11
      wr(8'h03, 8'h08);          // rising type only, master off
      @(negedge clk);
      addr = 8'h02;
      lines[11] = 1'b1;
      @(negedge clk); @(negedge clk);
      #1 check("R11 not before third edge", {31'h0, rdata[0]}, 32'h0);
      @(negedge clk);
      #1 check("R3 rise latched", {31'h0, rdata[0]}, 32'h1);
      check("R8 no irq without master", {31'h0, irq}, 32'h0);
      wr(8'h01, 8'h08);
      expect_status("R7 edge cleared", 8'h00);
   endtask

   task automatic t_masked();
      set_line(10, 1'b1);                      // mask bit clear
      expect_status("R5 unmasked line rise", 8'h00);
      set_line(11, 1'b0);                      // no falling mask on line 11
      expect_status("R5 fall without mask", 8'h00);
      wr(8'h53, 8'h08);                        // falling mask on line 11
      set_line(11, 1'b1);                      // rising qualifies
      wr(8'h01, 8'h08);
      wr(8'h03, 8'h08);                        // falling type disabled
      set_line(11, 1'b0);
      expect_status("R5 fall type disabled", 8'h00);
      wr(8'h03, 8'h00);
      set_line(11, 1'b1);
      expect_status("R5 rise type disabled", 8'h00);
      wr(8'h53, 8'h00);
      set_line(10, 1'b0);
      set_line(11, 1'b0);
      expect_status("R5 still empty", 8'h00);
   endtask

   task automatic t_fall_overflow();
      wr(8'h73, 8'h80);                        // port3 bit7 = line 31
      wr(8'h03, 8'h18);
      set_line(31, 1'b1);
      expect_status("R5 rise on fall-only line", 8'h00);
      set_line(31, 1'b0);
      expect_status("R4 fall latched", 8'h01);
      set_line(31, 1'b1);
      set_line(31, 1'b0);
      expect_status("R6 overflow set", 8'h03);
      wr(8'h01, 8'h03);
      expect_status("R7 other bits no effect", 8'h03);
      wr(8'h01, 8'h04);
      expect_status("R7 overflow only cleared", 8'h01);
      wr(8'h01, 8'h08);
      expect_status("R7 edge cleared", 8'h00);
      set_line(31, 1'b1); set_line(31, 1'b0);
      set_line(31, 1'b1); set_line(31, 1'b0);
      expect_status("R6 overflow again", 8'h03);
      wr(8'h01, 8'h0C);
      expect_status("R7 both cleared", 8'h00);
      wr(8'h03, 8'h00);
   endtask

   task automatic t_irq();
      wr(8'h01, 8'h0C);
      wr(8'h03, 8'h1D);
      set_line(11, 1'b1);
      check("R9 armed irq", {31'h0, irq}, 32'h1);
      expect_status("R8 status mirrors irq", 8'h05);
      wr(8'h03, 8'h00);
      check("R9 disarm drops irq", {31'h0, irq}, 32'h0);
      expect_status("R9 flag kept", 8'h01);
      wr(8'h03, 8'h1E);                        // overflow-only interrupt
      check("R8 edge enable off", {31'h0, irq}, 32'h0);
      set_line(11, 1'b0);
      set_line(11, 1'b1);
      check("R8 overflow irq", {31'h0, irq}, 32'h1);
      expect_status("R8 overflow status", 8'h07);
      wr(8'h01, 8'h04);
      check("R8 irq after ovf clear", {31'h0, irq}, 32'h0);
      expect_status("R7 edge remains", 8'h01);
      wr(8'h03, 8'h00);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_regmap();
      t_rise_latency();
      t_masked();
      t_fall_overflow();
      t_irq();
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

endmodule